// File: doc/BRIEF.md
# Byte-Program and Verify Sequencer for a Parallel EPROM

This block runs the complete write flow for a one-time or UV-erasable parallel EPROM. A single `start` pulse begins a run. The block first puts the device into its margin-verify condition. It then works through every address from zero upward. For each byte it does three things in turn:

- it reads the byte already in the device;
- it applies fixed-width chip-enable program pulses while the programming supply is on;
- it reads the byte back after every pulse.

When the read-back matches the target value, the block moves to the next address straight away. It gives no extra pulses after a match.

After the last address, the block takes the device out of margin mode. It then reads every byte twice: once at a raised supply level and once at a lowered one. Target bytes come from a source interface that is addressed by the same address bus as the device. Generating the voltages is left to outside circuitry. The block only drives abstract enables: a programming-supply enable and a 2-bit supply-level select. At the end of a run the block raises `done`, together with a pass flag and the address that failed.

States:

| State | Purpose |
|---|---|
| `S_IDLE` | Waits for `start`. |
| `S_MSET` | Sets margin mode. |
| `S_PRE` | Reads the byte before any pulse. |
| `S_SETUP` | Sets up address and data. |
| `S_PULSE` | Applies one program pulse. |
| `S_HOLD` | Holds address and data after the pulse. |
| `S_VERIFY` | Reads the byte back after a pulse. |
| `S_MRST` | Resets margin mode. |
| `S_CHK_HI` | Checks a byte at the raised supply. |
| `S_CHK_LO` | Checks a byte at the lowered supply. |
| `S_DONE` | Holds the result. |

A state always leaves when its timer expires, except `S_IDLE` and `S_DONE`, which leave on `start`. The transitions are:

- `start` takes `S_IDLE` or `S_DONE` to `S_MSET`.
- `S_MSET` goes to `S_PRE`.
- `S_PRE` goes to `S_DONE` as a failure if the target needs a 0 changed to 1. It advances if the byte already matches. Otherwise it goes to `S_SETUP`.
- `S_SETUP` goes to `S_PULSE`, `S_PULSE` goes to `S_HOLD`, and `S_HOLD` goes to `S_VERIFY`.
- `S_VERIFY` advances on a match. If the pulse cap has been reached it goes to `S_DONE` as a failure. Otherwise it goes back to `S_SETUP`.
- To advance means moving to `S_PRE` of the next address, or to `S_MRST` after the last address.
- `S_MRST` goes to `S_CHK_HI`.
- `S_CHK_HI` walks all addresses, then goes to `S_CHK_LO`.
- `S_CHK_LO` walks all addresses, then goes to `S_DONE` as a pass.
- A mismatch in either check state goes to `S_DONE` as a failure.

Top module: `prog_seq`

## Requirements
- R1: While reset is held, and in idle, `ce_n`=1, `oe_n`=1, `vpp_en`=0, `vsel`=0, `margin_set`=0, `margin_rst`=0, `done`=0 and `pass`=0.
- R2: After `start`, `margin_set` is high for exactly T_MRG cycles, with `vpp_en`=1 and `vsel`=1, before the first program pulse.
- R3: A program pulse is a stretch of `ce_n`=0 with `vpp_en`=1 lasting exactly T_PW cycles, during which `oe_n` stays 1.
- R4: Each pulse is preceded by exactly T_SU cycles and followed by exactly T_HD cycles of `vpp_en`=1, `ce_n`=1. `addr` and `wr_data` do not change while `vpp_en` stays 1.
- R5: After every pulse the byte is read with `ce_n`=0 and `oe_n`=0. On a match the block moves to the next address with no further pulse. A byte whose first read already matches gets no pulse. The pulse count per byte therefore equals the number of pulses the device needed.
- R6: If a byte still mismatches after MAX_PULSES pulses, the run ends with `done`=1, `pass`=0 and `fail_addr` set to that byte, after exactly MAX_PULSES pulses on it.
- R7: If the first read of a byte shows a bit that is 0 where the target has a 1, the run fails at that address without any pulse on that byte.
- R8: After the last address, `margin_rst` is high for T_MRG cycles with `vpp_en`=0. Then all bytes are read at `vsel`=2, then again at `vsel`=3, and then `vsel` returns to 0. The encoding of `vsel` is 0 nominal, 1 programming, 2 raised check, 3 lowered check.
- R9: A mismatch in either final check fails the run at that address. A failure at the raised level ends the run before the lowered level is applied.
- R10: A run that passes every check ends with `done`=1, `pass`=1 and `fail_addr`=0. `done` holds, with `ce_n`=1, `oe_n`=1 and `vpp_en`=0, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (accepted in idle or done) |
| addr | output | AW | Address to the device and to the target source |
| src_data | input | 8 | Target byte for `addr` |
| rd_data | input | 8 | Byte read from the device |
| wr_data | output | 8 | Byte driven to the device for programming |
| vpp_en | output | 1 | Programming-supply enable |
| vsel | output | 2 | Supply level: 0 nominal, 1 programming, 2 raised check, 3 lowered check |
| margin_set | output | 1 | Margin-mode set strobe |
| margin_rst | output | 1 | Margin-mode reset strobe |
| ce_n | output | 1 | Chip enable, active low (program pulse or read) |
| oe_n | output | 1 | Output enable, active low (read) |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without failure |
| fail_addr | output | AW | Address of the failing byte |

## Verification
Every timed phase lasts a whole number of cycles set by its parameter. The bench measures these phases at falling edges with running counters rather than fixed sample points:

- pulse width in T_PW cycles;
- setup and hold in T_SU and T_HD cycles;
- margin strobes in T_MRG cycles.

A read result takes effect on the clock edge that ends the read phase. Pass, fail and the failing address therefore appear together with `done`, one state register later. The bench polls for `done` at falling edges and samples the results there.

The device model counts pulses per byte at the falling edge after the pulse ends, so the no-over-program and pulse-cap checks are exact. A history of changes in `vsel` checks the order of supply levels.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MSET,
        S_PRE,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_VERIFY,
        S_MRST,
        S_CHK_HI,
        S_CHK_LO,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        VS_NOM    = 2'd0,
        VS_PROG   = 2'd1,
        VS_CHK_HI = 2'd2,
        VS_CHK_LO = 2'd3
    } vsel_e;

endpackage

// File: rtl/prog_seq_timer.sv
module prog_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/prog_seq_count.sv
module prog_seq_count #(
    parameter int MAX = 3,
    parameter int W   = $clog2(MAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         at_max
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= '0;
        else if (clr)  value <= '0;
        else if (inc)  value <= value + 1'b1;
    end

    assign at_max = (value == W'(MAX));

    // R6: the sequencer never steps a counter beyond its limit
    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> !at_max);

endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int AW         = 16,
    parameter int T_PW       = 100,
    parameter int T_SU       = 2,
    parameter int T_HD       = 2,
    parameter int T_RD       = 1,
    parameter int T_MRG      = 2,
    parameter int MAX_PULSES = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] addr,
    input  logic [7:0]    src_data,
    input  logic [7:0]    rd_data,
    output logic [7:0]    wr_data,
    output logic          vpp_en,
    output logic [1:0]    vsel,
    output logic          margin_set,
    output logic          margin_rst,
    output logic          ce_n,
    output logic          oe_n,
    output logic          done,
    output logic          pass,
    output logic [AW-1:0] fail_addr
);

    localparam int TW       = $clog2(T_PW + T_SU + T_HD + T_RD + T_MRG + 1);
    localparam int PW       = $clog2(MAX_PULSES + 1);
    localparam int LAST_ADR = (1 << AW) - 1;

    seq_state_e    state, state_nx;
    logic          expired;
    logic [TW-1:0] dur_nx;
    logic          addr_clr, addr_inc, addr_last;
    logic          pc_clr, pc_inc, pc_max;
    logic [PW-1:0] pcnt;
    logic          fin_pass, fin_fail;
    logic          pass_q;
    logic [AW-1:0] fail_q;
    logic          rd_match, needs_up;

    assign rd_match = (rd_data == src_data);
    assign needs_up = |(src_data & ~rd_data);
    assign wr_data  = src_data;

    function automatic logic [TW-1:0] phase_len(input seq_state_e s);
        unique case (s)
            S_MSET, S_MRST:                  return TW'(T_MRG - 1);
            S_PRE, S_VERIFY,
            S_CHK_HI, S_CHK_LO:              return TW'(T_RD - 1);
            S_SETUP:                         return TW'(T_SU - 1);
            S_PULSE:                         return TW'(T_PW - 1);
            S_HOLD:                          return TW'(T_HD - 1);
            default:                         return '0;
        endcase
    endfunction

    assign dur_nx = phase_len(state_nx);

    prog_seq_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(expired), .load_val(dur_nx), .expired(expired)
    );

    prog_seq_count #(.MAX(LAST_ADR), .W(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
        .value(addr), .at_max(addr_last)
    );

    prog_seq_count #(.MAX(MAX_PULSES), .W(PW)) u_pulses (
        .clk(clk), .rst_n(rst_n), .clr(pc_clr), .inc(pc_inc),
        .value(pcnt), .at_max(pc_max)
    );

    // next state and counter control
    always_comb begin
        state_nx = state;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        pc_clr   = 1'b0;
        pc_inc   = 1'b0;
        fin_pass = 1'b0;
        fin_fail = 1'b0;
        unique case (state)
            S_IDLE, S_DONE: begin
                if (start) begin
                    state_nx = S_MSET;
                    addr_clr = 1'b1;
                end
            end
            S_MSET: if (expired) begin
                state_nx = S_PRE;
                pc_clr   = 1'b1;
            end
            S_PRE, S_VERIFY: if (expired) begin
                if (state == S_PRE && needs_up) begin
                    state_nx = S_DONE;
                    fin_fail = 1'b1;
                end else if (rd_match) begin
                    pc_clr = 1'b1;
                    if (addr_last) begin
                        state_nx = S_MRST;
                    end else begin
                        state_nx = S_PRE;
                        addr_inc = 1'b1;
                    end
                end else if (state == S_VERIFY && pc_max) begin
                    state_nx = S_DONE;
                    fin_fail = 1'b1;
                end else begin
                    state_nx = S_SETUP;
                end
            end
            S_SETUP: if (expired) begin
                state_nx = S_PULSE;
                pc_inc   = 1'b1;
            end
            S_PULSE: if (expired) state_nx = S_HOLD;
            S_HOLD:  if (expired) state_nx = S_VERIFY;
            S_MRST: if (expired) begin
                state_nx = S_CHK_HI;
                addr_clr = 1'b1;
            end
            S_CHK_HI, S_CHK_LO: if (expired) begin
                if (!rd_match) begin
                    state_nx = S_DONE;
                    fin_fail = 1'b1;
                end else if (!addr_last) begin
                    addr_inc = 1'b1;
                end else if (state == S_CHK_HI) begin
                    state_nx = S_CHK_LO;
                    addr_clr = 1'b1;
                end else begin
                    state_nx = S_DONE;
                    fin_pass = 1'b1;
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // state and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            pass_q <= 1'b0;
            fail_q <= '0;
        end else begin
            state <= state_nx;
            if ((state == S_IDLE || state == S_DONE) && start) begin
                pass_q <= 1'b0;
                fail_q <= '0;
            end
            if (fin_pass) pass_q <= 1'b1;
            if (fin_fail) fail_q <= addr;
        end
    end

    // outputs decoded from state
    always_comb begin
        vpp_en     = 1'b0;
        vsel       = VS_NOM;
        margin_set = 1'b0;
        margin_rst = 1'b0;
        ce_n       = 1'b1;
        oe_n       = 1'b1;
        unique case (state)
            S_IDLE, S_DONE: ;
            S_MSET:   begin vpp_en = 1'b1; vsel = VS_PROG; margin_set = 1'b1; end
            S_PRE, S_VERIFY:
                      begin vsel = VS_PROG; ce_n = 1'b0; oe_n = 1'b0; end
            S_SETUP, S_HOLD:
                      begin vpp_en = 1'b1; vsel = VS_PROG; end
            S_PULSE:  begin vpp_en = 1'b1; vsel = VS_PROG; ce_n = 1'b0; end
            S_MRST:   begin vsel = VS_PROG; margin_rst = 1'b1; end
            S_CHK_HI: begin vsel = VS_CHK_HI; ce_n = 1'b0; oe_n = 1'b0; end
            S_CHK_LO: begin vsel = VS_CHK_LO; ce_n = 1'b0; oe_n = 1'b0; end
            default: ;
        endcase
    end

    assign done      = (state == S_DONE);
    assign pass      = pass_q;
    assign fail_addr = fail_q;

    assert_margin_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        margin_set |-> (vpp_en && vsel == VS_PROG && ce_n && oe_n));

    assert_pulse_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && vpp_en) |-> oe_n);

    assert_bus_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_en && $past(vpp_en)) |-> ($stable(addr) && $stable(wr_data)));

    assert_pulse_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PW'(MAX_PULSES));

    assert_margin_rst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        margin_rst |-> (!vpp_en && ce_n && oe_n));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ce_n && oe_n && !vpp_en && vsel == VS_NOM));

endmodule

// File: tb/prog_seq_bench.sv
module prog_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 2;
    localparam int T_PW  = 5;
    localparam int T_SU  = 2;
    localparam int T_HD  = 3;
    localparam int T_RD  = 1;
    localparam int T_MRG = 3;
    localparam int MAXP  = 25;
    localparam int NSC   = 4;

    // scenario vectors: byte [sc][addr]
    localparam logic [7:0] INIT [NSC][4] = '{
        '{8'hFF, 8'hFF, 8'hFF, 8'hFF},
        '{8'hFF, 8'hFF, 8'hFF, 8'hFF},
        '{8'hFF, 8'hFF, 8'h0F, 8'hFF},
        '{8'h11, 8'h22, 8'h33, 8'h44}};
    localparam logic [7:0] WANT [NSC][4] = '{
        '{8'hA5, 8'h3C, 8'h00, 8'hFF},
        '{8'h12, 8'h34, 8'h56, 8'h78},
        '{8'h80, 8'h01, 8'hF0, 8'hFE},
        '{8'h11, 8'h22, 8'h33, 8'h44}};
    localparam int NEED [NSC][4] = '{
        '{1, 3, 25, 1},
        '{1, 26, 1, 1},
        '{2, 4, 1, 1},
        '{1, 1, 1, 1}};
    localparam int EXP_PASS  [NSC] = '{1, 0, 0, 1};
    localparam int EXP_FADDR [NSC] = '{0, 1, 2, 0};
    localparam int EXP_PULSE [NSC] = '{29, 26, 6, 0};
    localparam int EXP_HIST  [NSC] = '{'h1230, 'h0010, 'h0010, 'h1230};
    localparam int EXP_MRST  [NSC] = '{T_MRG, 0, 0, T_MRG};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr;
    logic [7:0]    src_data, rd_data, wr_data;
    logic          vpp_en, margin_set, margin_rst, ce_n, oe_n, done, pass;
    logic [1:0]    vsel;
    logic [AW-1:0] fail_addr;

    int sc = 0;
    int weak_lo = -1;
    int weak_hi = -1;
    logic mon_clr = 1'b0;

    logic [7:0] mem [4];
    int pc [4];
    int pulses, bad_pw, bad_su, bad_hd, bad_mrg, mset_cyc, mrst_cyc;
    int pre_cnt, post_cnt, plen, hist;
    logic prev_pulse, in_post;
    logic [1:0] last_vsel;
    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign src_data = WANT[sc][addr];
    assign rd_data  = mem[addr] ^ (((vsel == 2'd3 && int'(addr) == weak_lo) ||
                                    (vsel == 2'd2 && int'(addr) == weak_hi)) ? 8'h01 : 8'h00);

    prog_seq #(.AW(AW), .T_PW(T_PW), .T_SU(T_SU), .T_HD(T_HD), .T_RD(T_RD),
               .T_MRG(T_MRG), .MAX_PULSES(MAXP)) u_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .src_data(src_data),
        .rd_data(rd_data), .wr_data(wr_data), .vpp_en(vpp_en), .vsel(vsel),
        .margin_set(margin_set), .margin_rst(margin_rst), .ce_n(ce_n), .oe_n(oe_n),
        .done(done), .pass(pass), .fail_addr(fail_addr));

    // device model and timing monitor
    always @(negedge clk) begin
        logic cur;
        if (mon_clr) begin
            for (int i = 0; i < 4; i++) begin mem[i] = INIT[sc][i]; pc[i] = 0; end
            pulses = 0; bad_pw = 0; bad_su = 0; bad_hd = 0; bad_mrg = 0;
            mset_cyc = 0; mrst_cyc = 0; pre_cnt = 0; post_cnt = 0; plen = 0;
            hist = 0; prev_pulse = 1'b0; in_post = 1'b0; last_vsel = vsel;
        end else begin
            cur = !ce_n && vpp_en;
            if (cur && !prev_pulse) begin
                if (pre_cnt != T_SU) bad_su++;
                if (mset_cyc != T_MRG) bad_mrg++;
                plen = 0;
                pre_cnt = 0;
            end
            if (cur) plen++;
            if (!cur && prev_pulse) begin
                if (plen != T_PW) bad_pw++;
                pulses++;
                pc[addr]++;
                if (pc[addr] >= NEED[sc][addr]) mem[addr] = mem[addr] & wr_data;
                in_post = 1'b1;
                post_cnt = 0;
            end
            if (vpp_en && ce_n) begin
                if (in_post) post_cnt++; else pre_cnt++;
            end
            if (!vpp_en) begin
                if (in_post) begin
                    if (post_cnt != T_HD) bad_hd++;
                    in_post = 1'b0;
                end
                pre_cnt = 0;
            end
            if (margin_set) mset_cyc++;
            if (margin_rst) mrst_cyc++;
            if (vsel != last_vsel) hist = ((hist << 4) | int'(vsel)) & 'hFFFF;
            last_vsel = vsel;
            prev_pulse = cur;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int s, input int wlo, input int whi, input int e_pass,
                       input int e_fa, input int e_hist, input int e_mrst, input string rtag);
        int t;
        @(posedge clk); #1;
        sc = s; weak_lo = wlo; weak_hi = whi; mon_clr = 1'b1;
        @(posedge clk); #1;
        mon_clr = 1'b0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        t = 0;
        while (!done && t < 20000) begin @(negedge clk); t++; end
        if (!done) begin
            chk(1'b0, "watchdog", t, 20000);
        end else begin
            @(negedge clk);
            chk(pass == e_pass, rtag, pass, e_pass);
            chk(int'(fail_addr) == e_fa, rtag, fail_addr, e_fa);
            chk(pulses == EXP_PULSE[s], "R5", pulses, EXP_PULSE[s]);
            chk(bad_pw == 0, "R3", bad_pw, 0);
            chk(bad_su == 0 && bad_hd == 0, "R4", bad_su + bad_hd, 0);
            chk(bad_mrg == 0 && mset_cyc == T_MRG, "R2", mset_cyc, T_MRG);
            chk(mrst_cyc == e_mrst, "R8", mrst_cyc, e_mrst);
            chk(hist == e_hist, "R8", hist, e_hist);
            repeat (4) @(negedge clk);
            chk(done && ce_n && oe_n && !vpp_en, "R10", {done, ce_n, oe_n, vpp_en}, 4'b1110);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: quiet outputs under reset
        chk(ce_n && oe_n && !vpp_en && vsel == 2'd0 && !margin_set && !margin_rst
            && !done && !pass, "R1",
            {ce_n, oe_n, vpp_en, vsel, margin_set, margin_rst, done, pass}, 9'b110000000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ce_n && oe_n && !vpp_en && !done, "R1", {ce_n, oe_n, vpp_en, done}, 4'b1100);

        for (int s = 0; s < NSC; s++) begin
            run(s, -1, -1, EXP_PASS[s], EXP_FADDR[s], EXP_HIST[s], EXP_MRST[s],
                (s == 1) ? "R6" : (s == 2) ? "R7" : "R10");
            if (s == 0) begin
                // R5: each byte got exactly the pulses it needed, none extra
                chk(pc[0] == 1 && pc[1] == 3 && pc[2] == 25 && pc[3] == 0, "R5",
                    pc[0] * 1000 + pc[1] * 100 + pc[2], 1325);
            end
            if (s == 1) chk(pc[1] == MAXP, "R6", pc[1], MAXP);
            if (s == 2) chk(pc[2] == 0 && mem[2] == 8'h0F, "R7", pc[2], 0);
        end

        // R9: lowered-supply check fails at address 3 after a clean raised pass
        run(0, 3, -1, 0, 3, 'h1230, T_MRG, "R9");
        // R9: raised-supply check fails at address 1; lowered level never applied
        run(0, -1, 1, 0, 1, 'h0120, T_MRG, "R9");
        // back-to-back restart from done: clean pass clears earlier failure
        run(3, -1, -1, 1, 0, 'h1230, T_MRG, "R10");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule